// File: doc/BRIEF.md
# Loop-Detection Watchdog Timer

This block watches for a runaway program. Software writes a single configuration word that enables watchdog mode, picks one of eight power-of-two timeout intervals, chooses the outcome and sets a run bit that starts counting on the watchdog clock. Software must write the run bit again before the interval runs out. Each such write clears the count and starts it again. If no write arrives in time, the block issues a one-cycle request: either a system reset request or a non-maskable interrupt request, depending on the outcome bit.

Power-state inputs decide whether the count moves. Stop and idle modes freeze the count, and so does running the CPU from the subclock. In each case the count value is kept. Halt mode does not stop the count, so software has to make sure a timeout cannot fall inside a halt. After a timeout the count starts again from zero. The watchdog therefore keeps firing at the same period until software services it or a system reset clears it.

Top module: `loop_watchdog`

## Requirements
- R1: After reset the configuration word reads back as zero and neither request output is high.
- R2: The configuration word has these fields: bit 0 is run, bit 1 selects the outcome (1 = reset request, 0 = interrupt request), bit 2 enables watchdog mode, and bits 5:3 hold the interval select. Every field reads back as written, except that run cannot be cleared.
- R3: Once run is 1, a write with bit 0 at 0 leaves run at 1 and counting carries on. Only a system reset clears it.
- R4: A select value s from 0 to 6 gives a timeout of 2^(MIN_EXP+s) counted cycles. Select value 7 gives 2^(MIN_EXP+8). No select value gives 2^(MIN_EXP+7).
- R5: A write with bit 0 at 1 clears the count, and the next timeout comes a full interval after that write.
- R6: A timeout produces a single-cycle pulse on the output chosen by the outcome bit. The other output stays low.
- R7: After a timeout the count restarts from zero, so with no servicing the requests repeat once every interval.
- R8: While stop or idle is high the count does not advance, and it keeps its value.
- R9: The halt input has no effect on counting.
- R10: While the CPU-on-subclock input is high the count does not advance, and it keeps its value.
- R11: While watchdog mode is disabled no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog count clock |
| rst_n | input | 1 | Active-low system reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration write data |
| cfg_rdata | output | 6 | Configuration read-back |
| stop_i | input | 1 | Stop mode active |
| idle_i | input | 1 | Idle mode active |
| halt_i | input | 1 | Halt mode active |
| subclk_i | input | 1 | CPU running from subclock |
| rst_req_o | output | 1 | System reset request pulse |
| nmi_req_o | output | 1 | Non-maskable interrupt request pulse |

## Verification
All eight interval selects are timed with the outcome bit alternating. This shows whether the interval table is right, including the gap at select 7, and whether the pulse lands on the correct output. Some runs hold halt high and others pull stop, idle and subclock up at random. Comparing these shows whether each pause input holds the count without clearing it, and whether halt is ignored. Other directed sequences cover a mid-interval restart write, an attempt to clear run, back-to-back timeouts with no servicing, and disabled watchdog mode. These separate the restart behaviour, the sticky run bit and the enable gate from plain counting.

// File: rtl/loop_watchdog.sv
module loop_watchdog #(
  parameter int MIN_EXP     = 13,
  parameter bit HALT_COUNTS = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [5:0] cfg_wdata,
  output logic [5:0] cfg_rdata,
  input  logic       stop_i,
  input  logic       idle_i,
  input  logic       halt_i,
  input  logic       subclk_i,
  output logic       rst_req_o,
  output logic       nmi_req_o
);

  localparam int CW = MIN_EXP + 8;

  logic          run_q, rst_sel_q, en_q;
  logic [2:0]    sel_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_m1;
  int unsigned   shamt;

  wire kick   = cfg_we & cfg_wdata[0];
  wire hold   = stop_i | idle_i | subclk_i | (halt_i & ~HALT_COUNTS);
  wire active = run_q & en_q & ~hold;
  wire expire = active & (cnt_q >= lim_m1);

  always_comb begin
    shamt  = (sel_q == 3'd7) ? unsigned'(MIN_EXP + 8) : unsigned'(MIN_EXP) + {29'd0, sel_q};
    lim_m1 = (CW'(1) << shamt) - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      rst_sel_q <= 1'b0;
      en_q      <= 1'b0;
      sel_q     <= 3'd0;
    end else if (cfg_we) begin
      run_q     <= run_q | cfg_wdata[0];
      rst_sel_q <= cfg_wdata[1];
      en_q      <= cfg_wdata[2];
      sel_q     <= cfg_wdata[5:3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (kick)        cnt_q <= '0;
    else if (expire)      cnt_q <= '0;
    else if (active)      cnt_q <= cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_o <= 1'b0;
      nmi_req_o <= 1'b0;
    end else begin
      rst_req_o <= expire & ~kick &  rst_sel_q;
      nmi_req_o <= expire & ~kick & ~rst_sel_q;
    end
  end

  assign cfg_rdata = {sel_q, en_q, rst_sel_q, run_q};

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_req_o, nmi_req_o})); // R6
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o); // R6
  AST_NMI_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req_o |=> !nmi_req_o); // R6
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[0] |=> cfg_rdata[0]); // R3
  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == '0)); // R5
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((stop_i || idle_i || subclk_i) && !kick) |=> $stable(cnt_q)); // R8 R10
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !(rst_req_o || nmi_req_o)); // R11

endmodule

// File: tb/loop_watchdog_tb.sv
module loop_watchdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_EXP    = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic [5:0] cfg_rdata;
  logic stop_i = 1'b0, idle_i = 1'b0, halt_i = 1'b0, subclk_i = 1'b0;
  logic rst_req_o, nmi_req_o;

  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_watchdog #(.MIN_EXP(MIN_EXP), .HALT_COUNTS(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .stop_i(stop_i), .idle_i(idle_i), .halt_i(halt_i),
    .subclk_i(subclk_i), .rst_req_o(rst_req_o), .nmi_req_o(nmi_req_o));

  function automatic int exp_limit(input int sel);
    return 1 << (MIN_EXP + ((sel == 7) ? 8 : sel));
  endfunction

  function automatic logic [5:0] mk_cfg(input int sel, input bit en, input bit rsel, input bit run);
    return {sel[2:0], en, rsel, run};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [5:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // pmode: 0 free run, 1 halt held high, 2 random stop/idle/subclk pauses
  task automatic meas(input int lim, input bit want_rst, input int pmode, input string req);
    int act = 0;
    bit seen = 1'b0;
    bit was_active;
    for (int i = 0; i < 4*lim + 200 && !seen; i++) begin
      stop_i = 1'b0; idle_i = 1'b0; subclk_i = 1'b0; halt_i = (pmode == 1);
      if (pmode == 2 && ($urandom % 10) < 3) begin
        case ($urandom % 3)
          0: stop_i = 1'b1;
          1: idle_i = 1'b1;
          default: subclk_i = 1'b1;
        endcase
      end
      was_active = !(stop_i || idle_i || subclk_i);
      @(negedge clk);
      if (was_active) act++;
      if (rst_req_o || nmi_req_o) begin
        seen = 1'b1;
        chk(act == lim, req, act, lim);
        chk((want_rst ? rst_req_o : nmi_req_o) == 1'b1, "R6 selected output", 0, 1);
        chk((want_rst ? nmi_req_o : rst_req_o) == 1'b0, "R6 other output", 1, 0);
      end
    end
    stop_i = 1'b0; idle_i = 1'b0; subclk_i = 1'b0; halt_i = 1'b0;
    if (!seen) chk(1'b0, {req, " no timeout"}, 0, 1);
    @(negedge clk);
    chk(!rst_req_o && !nmi_req_o, "R6 pulse width", int'(rst_req_o | nmi_req_o), 0);
    act = 1;
  endtask

  initial begin
    void'($urandom(32'h5EED_0C1D));
    repeat (3) @(negedge clk);
    chk(cfg_rdata == 6'd0, "R1 reset config", cfg_rdata, 0);
    chk(!rst_req_o && !nmi_req_o, "R1 reset requests", int'({rst_req_o, nmi_req_o}), 0);
    rst_n = 1'b1;

    // R2 field layout without run
    wr(mk_cfg(5, 1'b0, 1'b1, 1'b0));
    chk(cfg_rdata == 6'b101010, "R2 readback", cfg_rdata, 6'b101010);

    // R11 disabled mode: run set but enable low
    wr(mk_cfg(0, 1'b0, 1'b1, 1'b1));
    begin
      int hits = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (rst_req_o || nmi_req_o) hits++;
      end
      chk(hits == 0, "R11 no request while disabled", hits, 0);
    end

    // R4 R6 every interval select, alternating outcome
    for (int s = 0; s < 8; s++) begin
      bit rs = s[0];
      wr(mk_cfg(s, 1'b1, rs, 1'b1));
      meas(exp_limit(s), rs, 0, "R4 interval");
    end

    // R7 repeat without servicing (sel 1, nmi)
    wr(mk_cfg(1, 1'b1, 1'b0, 1'b1));
    meas(exp_limit(1), 1'b0, 0, "R4 first period");
    meas(exp_limit(1) - 1, 1'b0, 0, "R7 second period");

    // R5 restart mid-interval
    wr(mk_cfg(2, 1'b1, 1'b1, 1'b1));
    begin
      int hits = 0;
      for (int i = 0; i < exp_limit(2) - 6; i++) begin
        @(negedge clk);
        if (rst_req_o || nmi_req_o) hits++;
      end
      chk(hits == 0, "R5 early no request", hits, 0);
    end
    wr(mk_cfg(2, 1'b1, 1'b1, 1'b1));
    meas(exp_limit(2), 1'b1, 0, "R5 restart interval");

    // R3 run cannot be cleared
    wr(mk_cfg(3, 1'b1, 1'b0, 1'b1));
    wr(mk_cfg(3, 1'b1, 1'b0, 1'b0));
    chk(cfg_rdata[0] == 1'b1, "R3 run sticky", cfg_rdata[0], 1);
    meas(exp_limit(3) - 2, 1'b0, 0, "R3 still counting");

    // R9 halt ignored
    wr(mk_cfg(4, 1'b1, 1'b1, 1'b1));
    meas(exp_limit(4), 1'b1, 1, "R9 halt counts");

    // R8 R10 random pauses, several selects
    for (int k = 0; k < 6; k++) begin
      int s = $urandom % 8;
      bit rs = $urandom % 2;
      wr(mk_cfg(s, 1'b1, rs, 1'b1));
      meas(exp_limit(s), rs, 2, "R8 R10 paused interval");
    end

    // R1 reset clears a running watchdog
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(cfg_rdata == 6'd0, "R1 reset mid-run", cfg_rdata, 0);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule